// File: doc/BRIEF.md
# Subscriber Line Switch State Controller

This block is the digital control core of a four-switch line access device that stands in for an electromechanical ringing relay on an analog line card. It turns a ringing-select pin, a latch-enable pin and an open-drain all-off/thermal pin, together with supply, thermal and battery conditions, into enables for two break switches (tip and ring toward the line interface circuit), a ringing-return switch and a ringing switch. The analog switches, current limiting and protection clamps sit outside the block.

Three switch states exist: talk (break switches closed, ringing pair open), ringing (the reverse) and all-off. A transparent latch on the ringing-select input lets a shared latch-enable freeze many ports. Overrides from supply lock-out, battery hysteresis, the thermal flag and the all-off pin always beat the latch. After power-up the block stays in all-off until latch-enable has been seen low. The ringing switch opens only on a ringing-current zero-crossing. So a direct ringing-to-talk change gives make-before-break, and pulling the all-off pin low first gives break-before-make.

Top module: `line_switch_ctrl`

## Requirements
- R1: During and straight after reset all four switch enables and the pin pull-down output are 0.
- R2: With no override active, ring_sel_pin = 1 selects ringing (ret_en = 1, ring_en = 1, brk_en = 0) and ring_sel_pin = 0 selects talk (brk_en = 1, ret_en = 0). brk_en and ret_en are never 1 together.
- R3: While hold_pin = 0 the ringing selection follows ring_sel_pin. While hold_pin = 1 it keeps the value present when hold_pin was last 0, and ring_sel_pin changes have no effect on the outputs.
- R4: alloff_pin_n = 0 forces brk_en = 0 and ret_en = 0 whatever hold_pin and ring_sel_pin are.
- R5: overtemp = 1 forces brk_en = 0, ret_en = 0 and alloff_drive_low = 1. When overtemp returns to 0, alloff_drive_low returns to 0 and normal control resumes by itself.
- R6: supply_ok = 0 forces brk_en = 0 and ret_en = 0 and clears the armed condition. Once supply_ok = 1, the block stays in all-off until hold_pin has been sampled 0 at least once. A held-high (undriven) hold_pin keeps it in all-off.
- R7: batt_mv is a signed millivolt value. A value above TRIP_MV (default -10000) forces all-off. All-off then holds until a value below RESTORE_MV (default -15000) is seen, and values between the two thresholds keep whichever condition was last set. The state after reset is tripped.
- R8: When ringing is no longer selected, ret_en drops with the state change, but ring_en stays 1 until a cycle with zc_pulse = 1. ring_en goes from 1 to 0 only on such a cycle.
- R9: A direct ringing-to-talk change sets brk_en = 1 in the same cycle as ret_en falls, while ring_en is still 1 (make-before-break).
- R10: Every input (pins, supply_ok, overtemp and the battery comparisons) passes through SYNC_STAGES flops. A change applied before clock edge 1 shows on the outputs after edge SYNC_STAGES+1 and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ring_sel_pin | input | 1 | Ringing-select pin, 1 = ringing, 0 = talk (asynchronous) |
| hold_pin | input | 1 | Latch-enable pin, 1 = hold (reads 1 when undriven) |
| alloff_pin_n | input | 1 | Sensed level of the open-drain all-off/thermal pin, 0 = force all-off |
| supply_ok | input | 1 | Supply above lock-out threshold |
| overtemp | input | 1 | Internal overtemperature flag |
| batt_mv | input | BATT_W | Signed battery sample in millivolts |
| zc_pulse | input | 1 | One-cycle pulse at each ringing-current zero-crossing |
| brk_en | output | 1 | Enable for both break switches |
| ret_en | output | 1 | Enable for the ringing-return switch |
| ring_en | output | 1 | Enable for the ringing switch |
| alloff_drive_low | output | 1 | Pulls the all-off/thermal pin low |

## Verification
The bench goes after ringing release outside a zero-crossing. A design that drops ring_en with the command, or that lets a later input change release it, would open the ringing switch under current. It checks the make-before-break cycle, where a design that delayed brk_en until the ringing switch opened would show an all-off gap. It probes battery values between the two thresholds from both sides, where a single-threshold design would chatter. It also checks hold_pin held high after a supply drop, where a design that re-armed on supply recovery alone would close switches on a board not yet set up. Random steps mix all overrides against a bench model of the latch, the arming and the hysteresis. Directed steps cover the exact sync latency.

// File: rtl/lsc_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the line switch controller: bit positions of the
// synchronized input vector, its reset value, and the switch mode type.
package lsc_pkg;
    localparam int PIN_RING = 0;  // ringing select
    localparam int PIN_HOLD = 1;  // latch enable
    localparam int PIN_AOFF = 2;  // all-off pin, active low
    localparam int PIN_SUP  = 3;  // supply valid
    localparam int PIN_OT   = 4;  // overtemperature
    localparam int PIN_BHI  = 5;  // battery above trip threshold
    localparam int PIN_BLO  = 6;  // battery below restore threshold
    localparam int PIN_N    = 7;

    // Reset value: hold and all-off pin read as pulled-up, everything else 0.
    localparam logic [PIN_N-1:0] PIN_RST = 7'b000_0110;

    typedef enum logic [1:0] {
        SW_OFF  = 2'd0,
        SW_TALK = 2'd1,
        SW_RING = 2'd2
    } sw_mode_t;
endpackage

// File: rtl/lsc_pin_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for a vector of asynchronous levels.
// Assumes each bit is an independent level; no pulse is carried through.
// Each stage resets to RST_VAL so reset-time pin levels are deterministic.
module lsc_pin_sync #(
    parameter int              W       = 7,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First capture flop, sees the raw asynchronous level.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= RST_VAL;
                else        stg[g] <= d;
            end
        end else begin : g_next
            // Later stages let any metastability settle.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= RST_VAL;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/lsc_batt_hyst.sv
`timescale 1ns/1ps
// Battery hysteresis. Takes the synchronized "above trip" and "below
// restore" comparisons and keeps a battery-good state. The current-cycle
// value is given combinationally so it lines up with the other synced inputs.
// Assumes the two comparisons are never both 1 (restore is below trip).
module lsc_batt_hyst (
    input  logic clk,
    input  logic rst_n,
    input  logic above_trip,
    input  logic below_restore,
    output logic batt_ok
);
    logic ok_q;

    // Next battery-good value: trip wins, restore sets, otherwise keep.
    always_comb begin
        if (above_trip)         batt_ok = 1'b0;
        else if (below_restore) batt_ok = 1'b1;
        else                    batt_ok = ok_q;
    end

    // Hold the battery-good state; reset starts tripped.
    always_ff @(posedge clk) begin
        if (!rst_n) ok_q <= 1'b0;
        else        ok_q <= batt_ok;
    end
endmodule

// File: rtl/lsc_cmd_gate.sv
`timescale 1ns/1ps
// Command gate: transparent latch on the ringing select, power-up arming,
// and priority of the overrides over the latched command.
// Assumes all inputs are already synchronized to clk.
module lsc_cmd_gate
    import lsc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ring_s,
    input  logic     hold_s,
    input  logic     aoff_n_s,
    input  logic     sup_s,
    input  logic     ot_s,
    input  logic     batt_ok,
    output sw_mode_t mode
);
    logic cmd_q;
    logic armed_q;
    logic armed_now;
    logic ring_cmd;
    logic force_off;

    // Capture the select while the latch is open and the supply is good.
    always_ff @(posedge clk) begin
        if (!rst_n)                cmd_q <= 1'b0;
        else if (sup_s && !hold_s) cmd_q <= ring_s;
    end

    // Arming: lost with the supply, gained when hold is seen low.
    always_comb begin
        if (!sup_s)       armed_now = 1'b0;
        else if (!hold_s) armed_now = 1'b1;
        else              armed_now = armed_q;
    end

    // Keep the armed state between cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= armed_now;
    end

    // Transparent latch output: live input when open, stored when held.
    assign ring_cmd  = hold_s ? cmd_q : ring_s;

    // Any override forces all-off regardless of the latch.
    assign force_off = !sup_s || !armed_now || !batt_ok || !aoff_n_s || ot_s;

    // Select the requested switch mode.
    always_comb begin
        if (force_off)     mode = SW_OFF;
        else if (ring_cmd) mode = SW_RING;
        else               mode = SW_TALK;
    end
endmodule

// File: rtl/lsc_switch_seq.sv
`timescale 1ns/1ps
// Switch sequencer: registers the switch enables from the requested mode.
// The ringing switch closes with the ringing mode but opens only on a
// zero-crossing pulse. Assumes zc_pulse is synchronous to clk.
module lsc_switch_seq
    import lsc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  sw_mode_t mode,
    input  logic     zc_pulse,
    input  logic     ot_s,
    output logic     brk_en,
    output logic     ret_en,
    output logic     ring_en,
    output logic     drive_low
);
    // Break and return enables follow the mode in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            brk_en <= 1'b0;
            ret_en <= 1'b0;
        end else begin
            brk_en <= (mode == SW_TALK);
            ret_en <= (mode == SW_RING);
        end
    end

    // Ringing switch: set by ringing mode, released only at zero current.
    always_ff @(posedge clk) begin
        if (!rst_n)               ring_en <= 1'b0;
        else if (mode == SW_RING) ring_en <= 1'b1;
        else if (zc_pulse)        ring_en <= 1'b0;
    end

    // Report the thermal condition by pulling the shared pin low.
    always_ff @(posedge clk) begin
        if (!rst_n) drive_low <= 1'b0;
        else        drive_low <= ot_s;
    end
endmodule

// File: rtl/line_switch_ctrl.sv
`timescale 1ns/1ps
// Subscriber line switch state controller (top).
// Synchronizes pins, flags and battery comparisons through one pipeline so
// they reach the state logic in the same cycle. It then gates the latched
// ringing command with the overrides and sequences the four switch enables.
// Assumes TRIP_MV > RESTORE_MV and both fit in BATT_W signed bits.
module line_switch_ctrl
    import lsc_pkg::*;
#(
    parameter int BATT_W      = 18,
    parameter int TRIP_MV     = -10000,
    parameter int RESTORE_MV  = -15000,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ring_sel_pin,
    input  logic                     hold_pin,
    input  logic                     alloff_pin_n,
    input  logic                     supply_ok,
    input  logic                     overtemp,
    input  logic signed [BATT_W-1:0] batt_mv,
    input  logic                     zc_pulse,
    output logic                     brk_en,
    output logic                     ret_en,
    output logic                     ring_en,
    output logic                     alloff_drive_low
);
    localparam logic signed [BATT_W-1:0] TRIP_V    = BATT_W'(TRIP_MV);
    localparam logic signed [BATT_W-1:0] RESTORE_V = BATT_W'(RESTORE_MV);

    logic [PIN_N-1:0] raw;
    logic [PIN_N-1:0] syn;
    logic             batt_ok;
    sw_mode_t         mode;

    // Gather the asynchronous levels into one vector.
    always_comb begin
        raw           = '0;
        raw[PIN_RING] = ring_sel_pin;
        raw[PIN_HOLD] = hold_pin;
        raw[PIN_AOFF] = alloff_pin_n;
        raw[PIN_SUP]  = supply_ok;
        raw[PIN_OT]   = overtemp;
        raw[PIN_BHI]  = (batt_mv > TRIP_V);
        raw[PIN_BLO]  = (batt_mv < RESTORE_V);
    end

    lsc_pin_sync #(
        .W       (PIN_N),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_RST)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw),
        .q     (syn)
    );

    lsc_batt_hyst batt_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .above_trip    (syn[PIN_BHI]),
        .below_restore (syn[PIN_BLO]),
        .batt_ok       (batt_ok)
    );

    lsc_cmd_gate gate_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ring_s   (syn[PIN_RING]),
        .hold_s   (syn[PIN_HOLD]),
        .aoff_n_s (syn[PIN_AOFF]),
        .sup_s    (syn[PIN_SUP]),
        .ot_s     (syn[PIN_OT]),
        .batt_ok  (batt_ok),
        .mode     (mode)
    );

    lsc_switch_seq seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .zc_pulse  (zc_pulse),
        .ot_s      (syn[PIN_OT]),
        .brk_en    (brk_en),
        .ret_en    (ret_en),
        .ring_en   (ring_en),
        .drive_low (alloff_drive_low)
    );
endmodule

// File: rtl/lsc_checker.sv
`timescale 1ns/1ps
// Property checker for line_switch_ctrl, attached by bind.
// Delays the raw flags by the block latency with its own shift registers.
module lsc_checker #(
    parameter int SYNC_STAGES = 2
) (
    input logic clk,
    input logic rst_n,
    input logic supply_ok,
    input logic overtemp,
    input logic zc_pulse,
    input logic brk_en,
    input logic ret_en,
    input logic ring_en,
    input logic alloff_drive_low
);
    localparam int LAT = SYNC_STAGES + 1;

    logic [LAT-1:0] ot_d;
    logic [LAT-1:0] sup_d;
    logic [7:0]     cyc;

    // Delay lines matching the input-to-output latency, and a warm-up count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ot_d  <= '0;
            sup_d <= '0;
            cyc   <= '0;
        end else begin
            ot_d  <= {ot_d[LAT-2:0], overtemp};
            sup_d <= {sup_d[LAT-2:0], supply_ok};
            if (cyc < 8'd200) cyc <= cyc + 8'd1;
        end
    end

    // R2
    talk_ring_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(brk_en && ret_en));

    // R8
    ring_release_zc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ring_en) |-> $past(zc_pulse));

    // R8
    ret_needs_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_en |-> ring_en);

    // R5
    thermal_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 8'(LAT)) && ot_d[LAT-1] |-> alloff_drive_low && !brk_en && !ret_en);

    // R5
    thermal_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 8'(LAT)) && !ot_d[LAT-1] |-> !alloff_drive_low);

    // R6
    supply_lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 8'(LAT)) && !sup_d[LAT-1] |-> !brk_en && !ret_en);
endmodule

bind line_switch_ctrl lsc_checker #(.SYNC_STAGES(SYNC_STAGES)) chk_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .supply_ok        (supply_ok),
    .overtemp         (overtemp),
    .zc_pulse         (zc_pulse),
    .brk_en           (brk_en),
    .ret_en           (ret_en),
    .ring_en          (ring_en),
    .alloff_drive_low (alloff_drive_low)
);

// File: tb/line_switch_ctrl_tb_top.sv
`timescale 1ns/1ps
// Bench for line_switch_ctrl: directed corner cases then seeded random steps,
// compared against a reference model of latch, arming and battery hysteresis.
module line_switch_ctrl_tb_top;
    localparam int BATT_W = 18;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ring_sel_pin = 1'b0;
    logic hold_pin = 1'b1;
    logic alloff_pin_n = 1'b1;
    logic supply_ok = 1'b1;
    logic overtemp = 1'b0;
    logic signed [BATT_W-1:0] batt_mv = -18'sd48000;
    logic zc_pulse = 1'b0;
    logic brk_en, ret_en, ring_en, alloff_drive_low;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // model state
    bit m_armed = 0, m_latch = 0, m_bok = 0, m_ring = 0;
    bit e_brk = 0, e_ret = 0, e_drv = 0;

    always #2.5 clk = ~clk;

    line_switch_ctrl #(.BATT_W(BATT_W)) dut_i (
        .clk (clk), .rst_n (rst_n), .ring_sel_pin (ring_sel_pin),
        .hold_pin (hold_pin), .alloff_pin_n (alloff_pin_n),
        .supply_ok (supply_ok), .overtemp (overtemp), .batt_mv (batt_mv),
        .zc_pulse (zc_pulse), .brk_en (brk_en), .ret_en (ret_en),
        .ring_en (ring_en), .alloff_drive_low (alloff_drive_low)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp_v);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp_v);
        end
    endtask

    task automatic chk_all(input string tag);
        chk(brk_en === e_brk, tag, "brk_en", int'(brk_en), int'(e_brk));
        chk(ret_en === e_ret, tag, "ret_en", int'(ret_en), int'(e_ret));
        chk(ring_en === m_ring, tag, "ring_en", int'(ring_en), int'(m_ring));
        chk(alloff_drive_low === e_drv, tag, "alloff_drive_low",
            int'(alloff_drive_low), int'(e_drv));
    endtask

    // Reference model update for one settled set of inputs.
    task automatic model(input bit r, input bit h, input bit a, input bit s,
                         input bit o, input int b);
        bit eff, off;
        if (!s) m_armed = 0; else if (!h) m_armed = 1;
        if (s && !h) m_latch = r;
        if (b > -10000) m_bok = 0; else if (b < -15000) m_bok = 1;
        eff   = h ? m_latch : r;
        off   = !s || !m_armed || !m_bok || !a || o;
        e_brk = !off && !eff;
        e_ret = !off && eff;
        if (e_ret) m_ring = 1;
        e_drv = o;
    endtask

    // Apply inputs, let them settle, check; optionally pulse a zero-crossing.
    task automatic do_step(input bit r, input bit h, input bit a, input bit s,
                           input bit o, input int b, input bit z,
                           input string tag);
        @(negedge clk);
        ring_sel_pin = r; hold_pin = h; alloff_pin_n = a;
        supply_ok = s; overtemp = o; batt_mv = BATT_W'(b);
        model(r, h, a, s, o, b);
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk_all(tag);
        if (z) begin
            zc_pulse = 1'b1;
            @(posedge clk);
            @(negedge clk);
            zc_pulse = 1'b0;
            if (!e_ret) m_ring = 0;
            chk(ring_en === m_ring, tag, "ring_en after zc", int'(ring_en), int'(m_ring));
        end
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1f2e3d4c));
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: reset values
        chk_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R1");

        // R6: hold left high (undriven) keeps all-off after power-up
        do_step(0, 1, 1, 1, 0, -48000, 0, "R6");

        // R10: hold low reaches brk_en on edge 3, not edge 2
        @(negedge clk);
        hold_pin = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(brk_en === 1'b0, "R10", "brk_en early", int'(brk_en), 0);
        @(posedge clk);
        @(negedge clk);
        chk(brk_en === 1'b1, "R10", "brk_en on time", int'(brk_en), 1);
        do_step(0, 0, 1, 1, 0, -48000, 0, "R2");

        // R2: ringing, R9 direct change to talk, R8 release on zc
        do_step(1, 0, 1, 1, 0, -48000, 1, "R2");
        do_step(0, 0, 1, 1, 0, -48000, 0, "R9");
        do_step(0, 0, 1, 1, 0, -48000, 1, "R8");

        // R4: all-off pin low while ringing, even with hold high
        do_step(1, 0, 1, 1, 0, -48000, 0, "R2");
        do_step(1, 1, 0, 1, 0, -48000, 0, "R4");
        do_step(0, 1, 0, 1, 0, -48000, 1, "R4");
        do_step(1, 0, 0, 1, 0, -48000, 0, "R4");

        // R3: latch holds ringing while select changes
        do_step(1, 0, 1, 1, 0, -48000, 0, "R3");
        do_step(1, 1, 1, 1, 0, -48000, 0, "R3");
        do_step(0, 1, 1, 1, 0, -48000, 1, "R3");
        do_step(0, 0, 1, 1, 0, -48000, 1, "R3");

        // R5: thermal trip and recovery
        do_step(0, 0, 1, 1, 1, -48000, 0, "R5");
        do_step(0, 0, 1, 1, 0, -48000, 0, "R5");

        // R7: hysteresis from both sides
        do_step(0, 0, 1, 1, 0, -12000, 0, "R7");
        do_step(0, 0, 1, 1, 0, -5000, 0, "R7");
        do_step(0, 0, 1, 1, 0, -12000, 0, "R7");
        do_step(0, 0, 1, 1, 0, -16000, 0, "R7");

        // R6: supply loss, recovery with hold high, then arm again
        do_step(0, 0, 1, 0, 0, -48000, 0, "R6");
        do_step(0, 1, 1, 1, 0, -48000, 0, "R6");
        do_step(0, 0, 1, 1, 0, -48000, 0, "R6");

        // Random mix of all inputs.
        for (int i = 0; i < 400; i++) begin
            int bsel;
            int bv;
            bsel = int'($urandom % 4);
            bv = (bsel == 0) ? -5000 : (bsel == 1) ? -12000 :
                 (bsel == 2) ? -20000 : -48000;
            do_step(1'($urandom % 2), 1'($urandom % 2), ($urandom % 8) != 0,
                    ($urandom % 10) != 0, ($urandom % 10) == 0, bv,
                    1'($urandom % 2), "RND R2 R3 R4 R5 R6 R7 R8");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule